// File: doc/BRIEF.md
# Unpacked Floating-Point Adder Core

This core adds two floating-point operands held in unpacked form. Each operand carries a class code, a sign, a signed exponent and a fixed-point mantissa that has two integer bits. Special classes (zero, infinity, quiet NaN, signalling NaN) are resolved first, using a fixed class ranking. Two ordinary numbers are aligned on the larger exponent, and every mantissa bit shifted out of the smaller operand is folded into a sticky bit. The mantissas are then added or subtracted, the sign is fixed and the result is normalized. Subtraction is requested by a control pin that flips the second operand's sign on entry. A rounding-mode pin only decides the sign of exact-zero results. Rounding, repacking and exception flags belong to later stages.

Operands enter through a valid/ready stream and the result leaves through another one, one cycle later. A single output register holds the result. `in_ready` is high whenever that register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result and `out_valid` stay frozen, and a new operand pair is refused. `sub_op` and `round_mode` are sampled together with the operands.

Top module: `ufp_add_core`

## Requirements
- R1: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN. The operand with the higher code is taken as y, and on a tie the second operand is y. If y is a NaN of either kind, the result is y unchanged, so a signalling NaN in either position wins over a quiet NaN.
- R2: If y is infinity and x is an infinity of the other sign, the result is the default NaN (class 3, sign 0, exponent 0, mantissa 0). Any other case with y infinite returns y. Every NaN or infinity result has sticky 0.
- R3: With two zeros, the result is y with sign = AND of both signs. When `round_mode` is 3 (toward minus infinity), the sign is the OR of both signs instead. Sticky is 0.
- R4: If only x is zero, the result is y unchanged, with sticky 0.
- R5: For two numbers, the one with the larger signed exponent sets the result exponent (on a tie, x does). The other mantissa is shifted right by the exponent difference, and the OR of all bits shifted out is the result sticky. Equal exponents give sticky 0.
- R6: With equal signs, the mantissas are added. If the sum reaches 2.0 (bit 53 set), the sum is shifted right by one, its lost bit is ORed into the sticky and the exponent is incremented. The result sign is the sign of the larger-exponent operand.
- R7: With unlike signs, the core computes larger-exponent mantissa minus shifted mantissa minus sticky. An exactly-zero difference gives class 0, exponent 0, mantissa 0, keeps the alignment sticky, and has sign 1 only when `round_mode` is 3.
- R8: If that difference borrows out, it is negated in two's complement and the result takes the sign of the smaller-exponent operand.
- R9: A nonzero number result is normalized: it is shifted left until bit 52 (the 1.0 bit) is set, and the exponent drops by the shift count. Number results always have bit 52 set and bit 53 clear.
- R10: `sub_op` = 1 inverts the second operand's sign before any other step.
- R11: An accepted pair appears at the output on the next cycle. `in_ready` is low only while a held result waits with `out_ready` low, and a stalled result stays unchanged.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Core can take an operand pair |
| sub_op | input | 1 | 1: subtract (flip second operand sign) |
| round_mode | input | 2 | Rounding mode; 3 = toward minus infinity |
| a_cls | input | 3 | First operand class |
| a_sign | input | 1 | First operand sign |
| a_exp | input | EXP_W | First operand signed exponent |
| a_mant | input | MANT_W | First operand mantissa, bit 52 weighs 1.0 |
| b_cls | input | 3 | Second operand class |
| b_sign | input | 1 | Second operand sign |
| b_exp | input | EXP_W | Second operand signed exponent |
| b_mant | input | MANT_W | Second operand mantissa |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_cls | output | 3 | Result class |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Result signed exponent |
| res_mant | output | MANT_W | Result mantissa |
| res_sticky | output | 1 | OR of bits lost below the mantissa |

## Verification
The assertions assume that every operand of class number is normalized (bit 52 set, bit 53 clear), and that class codes stay within 0 to 4. Under those two conditions a borrow can only occur with equal exponents, and every number result comes out normalized. They also assume that a pair offered while `in_ready` is low is held unchanged. The stimulus builds number mantissas with the top two bits fixed at 01, and draws exponents from a few hundred around zero so that increments and normalizing shifts never wrap. It holds each offered pair until it is taken, and mixes tight exponent gaps, exact and near cancellations, and gaps wider than the mantissa.

// File: rtl/ufp_add_pkg.sv
`timescale 1ns/1ps
package ufp_add_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fcls_e;

  localparam logic [1:0] RM_DOWN = 2'd3;
endpackage

// File: rtl/ufp_order.sv
`timescale 1ns/1ps
// Ranks operands by class and resolves every non-arithmetic outcome.
module ufp_order import ufp_add_pkg::*; #(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [1:0]        rmode,
  input  logic [2:0]        a_cls,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [2:0]        b_cls,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              x_sign,
  output logic [EXP_W-1:0]  x_exp,
  output logic [MANT_W-1:0] x_mant,
  output logic              y_sign,
  output logic [EXP_W-1:0]  y_exp,
  output logic [MANT_W-1:0] y_mant,
  output logic              spec,
  output logic [2:0]        s_cls,
  output logic              s_sign,
  output logic [EXP_W-1:0]  s_exp,
  output logic [MANT_W-1:0] s_mant
);
  logic       swap;
  logic [2:0] x_cls, y_cls;

  assign swap   = a_cls > b_cls;
  assign x_cls  = swap ? b_cls  : a_cls;
  assign x_sign = swap ? b_sign : a_sign;
  assign x_exp  = swap ? b_exp  : a_exp;
  assign x_mant = swap ? b_mant : a_mant;
  assign y_cls  = swap ? a_cls  : b_cls;
  assign y_sign = swap ? a_sign : b_sign;
  assign y_exp  = swap ? a_exp  : b_exp;
  assign y_mant = swap ? a_mant : b_mant;

  always_comb begin
    spec   = 1'b1;
    s_cls  = y_cls;
    s_sign = y_sign;
    s_exp  = y_exp;
    s_mant = y_mant;
    if (y_cls == CLS_QNAN || y_cls == CLS_SNAN) begin
      spec = 1'b1;
    end else if (y_cls == CLS_INF) begin
      if (x_cls == CLS_INF && x_sign != y_sign) begin
        s_cls  = CLS_QNAN;
        s_sign = 1'b0;
        s_exp  = '0;
        s_mant = '0;
      end
    end else if (y_cls == CLS_ZERO) begin
      s_sign = (rmode == RM_DOWN) ? (x_sign | y_sign) : (x_sign & y_sign);
    end else if (x_cls == CLS_ZERO) begin
      spec = 1'b1;
    end else begin
      spec = 1'b0;
    end
  end

  AST_SNAN_RANKS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    vld && (a_cls == CLS_SNAN || b_cls == CLS_SNAN) |-> y_cls == CLS_SNAN); // R1
endmodule

// File: rtl/ufp_align.sv
`timescale 1ns/1ps
// Picks the larger-exponent operand and right-shifts the other, collecting sticky.
module ufp_align #(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic              x_sign,
  input  logic [EXP_W-1:0]  x_exp,
  input  logic [MANT_W-1:0] x_mant,
  input  logic              y_sign,
  input  logic [EXP_W-1:0]  y_exp,
  input  logic [MANT_W-1:0] y_mant,
  output logic              hi_sign,
  output logic [EXP_W-1:0]  hi_exp,
  output logic [MANT_W-1:0] hi_mant,
  output logic              lo_sign,
  output logic [MANT_W-1:0] lo_mant,
  output logic              sticky,
  output logic              exp_eq
);
  localparam int SHW = $clog2(MANT_W + 1);

  logic                  swap;
  logic [EXP_W-1:0]      lo_exp;
  logic [MANT_W-1:0]     lo_raw;
  logic [EXP_W:0]        ediff;
  logic [SHW-1:0]        sh;
  logic [2*MANT_W-1:0]   wide;

  assign swap    = $signed(x_exp) < $signed(y_exp);
  assign hi_sign = swap ? y_sign : x_sign;
  assign hi_exp  = swap ? y_exp  : x_exp;
  assign hi_mant = swap ? y_mant : x_mant;
  assign lo_sign = swap ? x_sign : y_sign;
  assign lo_exp  = swap ? x_exp  : y_exp;
  assign lo_raw  = swap ? x_mant : y_mant;
  assign exp_eq  = (x_exp == y_exp);

  assign ediff = {hi_exp[EXP_W-1], hi_exp} - {lo_exp[EXP_W-1], lo_exp};
  assign sh    = (ediff >= (EXP_W+1)'(MANT_W)) ? SHW'(MANT_W) : ediff[SHW-1:0];
  assign wide  = {lo_raw, {MANT_W{1'b0}}} >> sh;

  assign lo_mant = wide[2*MANT_W-1:MANT_W];
  assign sticky  = |wide[MANT_W-1:0];

  AST_EQ_EXP_NO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vld && exp_eq |-> !sticky); // R5
endmodule

// File: rtl/ufp_mant.sv
`timescale 1ns/1ps
// Mantissa add or subtract, borrow correction and normalization.
module ufp_mant import ufp_add_pkg::*; #(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [1:0]        rmode,
  input  logic              hi_sign,
  input  logic [EXP_W-1:0]  hi_exp,
  input  logic [MANT_W-1:0] hi_mant,
  input  logic              lo_sign,
  input  logic [MANT_W-1:0] lo_mant,
  input  logic              sticky_in,
  input  logic              exp_eq,
  output logic [2:0]        r_cls,
  output logic              r_sign,
  output logic [EXP_W-1:0]  r_exp,
  output logic [MANT_W-1:0] r_mant,
  output logic              r_sticky
);
  localparam int SHW = $clog2(MANT_W + 1);
  localparam int ONE = MANT_W - 2;

  logic [MANT_W-1:0] sum;
  logic [MANT_W:0]   dif;
  logic              borrow;
  logic [MANT_W-1:0] mag;
  logic [SHW-1:0]    lz;
  logic              found;

  assign sum    = hi_mant + lo_mant;
  assign dif    = {1'b0, hi_mant} - {1'b0, lo_mant} - {{MANT_W{1'b0}}, sticky_in};
  assign borrow = dif[MANT_W];
  assign mag    = borrow ? (~dif[MANT_W-1:0] + 1'b1) : dif[MANT_W-1:0];

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = ONE; i >= 0; i--) begin
      if (!found && mag[i]) begin
        found = 1'b1;
        lz    = SHW'(ONE - i);
      end
    end
  end

  always_comb begin
    r_cls    = CLS_NUM;
    r_sign   = hi_sign;
    r_exp    = hi_exp;
    r_mant   = sum;
    r_sticky = sticky_in;
    if (hi_sign == lo_sign) begin
      if (sum[MANT_W-1]) begin
        r_mant   = sum >> 1;
        r_sticky = sticky_in | sum[0];
        r_exp    = hi_exp + 1'b1;
      end
    end else if (dif == '0) begin
      r_cls  = CLS_ZERO;
      r_sign = (rmode == RM_DOWN);
      r_exp  = '0;
      r_mant = '0;
    end else begin
      r_sign = borrow ? lo_sign : hi_sign;
      r_mant = mag << lz;
      r_exp  = hi_exp - EXP_W'(lz);
    end
  end

  AST_BORROW_ONLY_EQ_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    vld && (hi_sign != lo_sign) && borrow |-> exp_eq); // R8
endmodule

// File: rtl/ufp_add_core.sv
`timescale 1ns/1ps
// Top: operand ranking, alignment, mantissa datapath, one output register stage.
module ufp_add_core import ufp_add_pkg::*; #(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              sub_op,
  input  logic [1:0]        round_mode,
  input  logic [2:0]        a_cls,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [2:0]        b_cls,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        res_cls,
  output logic              res_sign,
  output logic [EXP_W-1:0]  res_exp,
  output logic [MANT_W-1:0] res_mant,
  output logic              res_sticky
);
  logic              b_sign_eff, take, num_vld;
  logic              x_sign, y_sign, spec, s_sign;
  logic [EXP_W-1:0]  x_exp, y_exp, s_exp;
  logic [MANT_W-1:0] x_mant, y_mant, s_mant;
  logic [2:0]        s_cls;
  logic              hi_sign, lo_sign, al_sticky, exp_eq;
  logic [EXP_W-1:0]  hi_exp;
  logic [MANT_W-1:0] hi_mant, lo_mant;
  logic [2:0]        m_cls;
  logic              m_sign, m_sticky;
  logic [EXP_W-1:0]  m_exp;
  logic [MANT_W-1:0] m_mant;

  assign b_sign_eff = b_sign ^ sub_op;
  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;
  assign num_vld    = in_valid && !spec;

  ufp_order #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_order (
    .clk(clk), .rst_n(rst_n), .vld(in_valid), .rmode(round_mode),
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_sign(b_sign_eff), .b_exp(b_exp), .b_mant(b_mant),
    .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
    .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant),
    .spec(spec), .s_cls(s_cls), .s_sign(s_sign), .s_exp(s_exp), .s_mant(s_mant)
  );

  ufp_align #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
    .clk(clk), .rst_n(rst_n), .vld(num_vld),
    .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
    .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant),
    .hi_sign(hi_sign), .hi_exp(hi_exp), .hi_mant(hi_mant),
    .lo_sign(lo_sign), .lo_mant(lo_mant), .sticky(al_sticky), .exp_eq(exp_eq)
  );

  ufp_mant #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_mant (
    .clk(clk), .rst_n(rst_n), .vld(num_vld), .rmode(round_mode),
    .hi_sign(hi_sign), .hi_exp(hi_exp), .hi_mant(hi_mant),
    .lo_sign(lo_sign), .lo_mant(lo_mant), .sticky_in(al_sticky), .exp_eq(exp_eq),
    .r_cls(m_cls), .r_sign(m_sign), .r_exp(m_exp), .r_mant(m_mant), .r_sticky(m_sticky)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      res_cls    <= '0;
      res_sign   <= 1'b0;
      res_exp    <= '0;
      res_mant   <= '0;
      res_sticky <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        res_cls    <= spec ? s_cls  : m_cls;
        res_sign   <= spec ? s_sign : m_sign;
        res_exp    <= spec ? s_exp  : m_exp;
        res_mant   <= spec ? s_mant : m_mant;
        res_sticky <= spec ? 1'b0   : m_sticky;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_mant) && $stable(res_exp)
      && $stable(res_cls) && $stable(res_sign) && $stable(res_sticky)); // R11
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R11
  AST_NUM_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_cls == CLS_NUM |-> res_mant[MANT_W-2] && !res_mant[MANT_W-1]); // R9
  AST_SPECIAL_NO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_cls >= CLS_INF |-> !res_sticky); // R2
endmodule

// File: tb/ufp_add_core_tb.sv
`timescale 1ns/1ps
module ufp_add_core_tb_top;
  localparam int EW = 16;
  localparam int MW = 54;

  typedef struct {
    logic [2:0] ac; logic as; logic [EW-1:0] ae; logic [MW-1:0] am;
    logic [2:0] bc; logic bs; logic [EW-1:0] be; logic [MW-1:0] bm;
    logic sub; logic [1:0] rm; string req;
  } vec_t;

  typedef struct {
    logic [2:0] cls; logic sign; logic [EW-1:0] exp; logic [MW-1:0] mant;
    logic sticky; string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, sub_op = 1'b0, out_ready = 1'b0;
  logic [1:0] round_mode = '0;
  logic [2:0] a_cls = '0, b_cls = '0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [MW-1:0] a_mant = '0, b_mant = '0;
  logic in_ready, out_valid, res_sign, res_sticky;
  logic [2:0] res_cls;
  logic [EW-1:0] res_exp;
  logic [MW-1:0] res_mant;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  vec_t vecs[$];
  exp_t q[$];

  always #5 clk = ~clk;

  ufp_add_core #(.EXP_W(EW), .MANT_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sub_op(sub_op), .round_mode(round_mode),
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_cls(res_cls), .res_sign(res_sign), .res_exp(res_exp),
    .res_mant(res_mant), .res_sticky(res_sticky)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Behavioural reference: plain integers, loops for shifting.
  function automatic exp_t ref_add(vec_t v);
    exp_t r;
    logic [2:0] xc, yc;
    logic xs, ys, ps, qs;
    int xe, ye, pe, qe, d, e;
    longint xm, ym, mp, mq, s;
    bit st;
    logic bsg;
    bsg = v.bs ^ v.sub;
    if (v.ac > v.bc) begin
      xc = v.bc; xs = bsg;  xe = int'($signed(v.be)); xm = longint'(v.bm);
      yc = v.ac; ys = v.as; ye = int'($signed(v.ae)); ym = longint'(v.am);
    end else begin
      xc = v.ac; xs = v.as; xe = int'($signed(v.ae)); xm = longint'(v.am);
      yc = v.bc; ys = bsg;  ye = int'($signed(v.be)); ym = longint'(v.bm);
    end
    r.cls = yc; r.sign = ys; r.exp = EW'(ye); r.mant = MW'(ym); r.sticky = 1'b0;
    if (yc >= 3) begin
      r.req = "R1";
    end else if (yc == 2) begin
      r.req = "R2";
      if (xc == 2 && xs != ys) begin
        r.cls = 3; r.sign = 0; r.exp = 0; r.mant = 0;
      end
    end else if (yc == 0) begin
      r.req = "R3";
      r.sign = (v.rm == 2'd3) ? (xs | ys) : (xs & ys);
    end else if (xc == 0) begin
      r.req = "R4";
    end else begin
      if (xe < ye) begin
        pe = ye; ps = ys; mp = ym; qe = xe; qs = xs; mq = xm;
      end else begin
        pe = xe; ps = xs; mp = xm; qe = ye; qs = ys; mq = ym;
      end
      d = pe - qe;
      st = 0;
      if (d >= MW) begin
        st = (mq != 0); mq = 0;
      end else begin
        for (int k = 0; k < d; k++) begin
          st = st | mq[0];
          mq = mq >> 1;
        end
      end
      r.req = (d > 0) ? "R5" : "R6";
      e = pe;
      r.cls = 1;
      if (ps == qs) begin
        s = mp + mq;
        r.sign = ps;
        if (s >= (64'd1 << 53)) begin
          st = st | s[0]; s = s >> 1; e = e + 1; r.req = "R6";
        end
      end else begin
        s = mp - mq - longint'(st);
        if (s == 0) begin
          r.cls = 0; r.sign = (v.rm == 2'd3); s = 0; e = 0; r.req = "R7";
        end else begin
          if (s < 0) begin
            s = -s; r.sign = qs; r.req = "R8";
          end else begin
            r.sign = ps;
          end
          while (s < (64'd1 << 52)) begin
            s = s << 1; e = e - 1;
            if (r.req != "R8") r.req = "R9";
          end
        end
      end
      r.exp = EW'(e); r.mant = MW'(s); r.sticky = st;
    end
    if (v.req != "") r.req = v.req;
    return r;
  endfunction

  function automatic logic [MW-1:0] rmant();
    logic [63:0] w;
    w = {$urandom, $urandom};
    return {2'b01, w[MW-3:0]};
  endfunction

  function automatic vec_t mk(input logic [2:0] ac, input logic as, input int ae, input logic [MW-1:0] am,
                              input logic [2:0] bc, input logic bs, input int be, input logic [MW-1:0] bm,
                              input logic sub, input logic [1:0] rm, input string req);
    vec_t v;
    v.ac = ac; v.as = as; v.ae = EW'(ae); v.am = am;
    v.bc = bc; v.bs = bs; v.be = EW'(be); v.bm = bm;
    v.sub = sub; v.rm = rm; v.req = req;
    return v;
  endfunction

  localparam logic [MW-1:0] ONE  = 54'd1 << 52;
  localparam logic [MW-1:0] ONEH = (54'd3 << 51);

  task automatic build();
    // R1: signalling NaN outranks quiet NaN in either slot; tie keeps second
    vecs.push_back(mk(4, 0, 5, 54'h11, 3, 1, 7, 54'h22, 0, 0, "R1"));
    vecs.push_back(mk(3, 1, 5, 54'h33, 4, 0, 9, 54'h44, 0, 0, "R1"));
    vecs.push_back(mk(4, 1, 1, 54'h55, 4, 0, 2, 54'h66, 0, 0, "R1"));
    vecs.push_back(mk(3, 0, 0, 54'h77, 1, 0, 3, ONE,     0, 0, "R1"));
    // R2: opposite infinities give default NaN; same-sign infinity passes
    vecs.push_back(mk(2, 0, 0, 0, 2, 1, 0, 0, 0, 0, "R2"));
    vecs.push_back(mk(2, 1, 0, 0, 1, 0, 4, ONE, 0, 0, "R2"));
    // R3: zero sign rules under default and toward-minus-infinity modes
    vecs.push_back(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R3"));
    vecs.push_back(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 3, "R3"));
    vecs.push_back(mk(0, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R3"));
    // R4: zero plus a number returns the number
    vecs.push_back(mk(0, 1, 0, 0, 1, 1, -7, ONEH, 0, 0, "R4"));
    // R6: 1.0 + 1.0 carries into bit 53
    vecs.push_back(mk(1, 0, 3, ONE, 1, 0, 3, ONE, 0, 0, "R6"));
    // R10 / R7: x - x cancels, sign set only under mode 3
    vecs.push_back(mk(1, 0, 3, ONEH, 1, 0, 3, ONEH, 1, 0, "R10"));
    vecs.push_back(mk(1, 0, 3, ONEH, 1, 0, 3, ONEH, 1, 3, "R7"));
    // R8: 1.0 - 1.5 borrows, result -0.5 normalized to exponent -1
    vecs.push_back(mk(1, 0, 0, ONE, 1, 1, 0, ONEH, 0, 0, "R8"));
    // R5: wide exponent gap pushes all bits into sticky
    vecs.push_back(mk(1, 0, 80, ONE, 1, 0, 10, ONEH, 0, 0, "R5"));
    vecs.push_back(mk(1, 0, 20, ONE, 1, 1, 17, ONE | 54'h5, 0, 0, "R5"));
    for (int n = 0; n < 400; n++) begin
      vec_t v;
      int ea, eb, kind;
      logic [2:0] cl;
      kind = int'($urandom % 10);
      ea = int'($urandom % 400) - 200;
      eb = (kind < 6) ? ea + int'($urandom % 7) - 3 : ea + int'($urandom % 140) - 70;
      v = mk(1, 1'($urandom), ea, rmant(), 1, 1'($urandom), eb, rmant(),
             1'($urandom), 2'($urandom), "");
      if (kind == 0) begin
        v.be = v.ae; v.bm = v.am ^ MW'($urandom % 16); v.bs = v.as; v.sub = 1'b1;
      end
      if (kind == 9) begin
        cl = 3'($urandom % 5);
        v.ac = cl;
        if (cl != 1) v.am = ((cl == 0) || (cl == 2)) ? '0 : MW'($urandom);
        cl = 3'($urandom % 5);
        v.bc = cl;
        if (cl != 1) v.bm = ((cl == 0) || (cl == 2)) ? '0 : MW'($urandom);
      end
      vecs.push_back(v);
    end
  endtask

  initial begin : wdog
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int idx;
    bit pending, stall_prev;
    logic [2:0] h_cls; logic h_sign, h_st; logic [EW-1:0] h_exp; logic [MW-1:0] h_mant;
    exp_t e;
    void'($urandom(32'd7));
    build();
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R12", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R12", "in_ready after reset", longint'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idx = 0; pending = 0; stall_prev = 0;
    h_cls = '0; h_sign = 0; h_st = 0; h_exp = '0; h_mant = '0;
    while (idx < vecs.size() || q.size() != 0) begin
      @(negedge clk);
      out_ready = (($urandom % 4) != 0);
      if (!pending) begin
        if (idx < vecs.size() && ($urandom % 8) != 0) begin
          in_valid = 1'b1;
          a_cls = vecs[idx].ac; a_sign = vecs[idx].as; a_exp = vecs[idx].ae; a_mant = vecs[idx].am;
          b_cls = vecs[idx].bc; b_sign = vecs[idx].bs; b_exp = vecs[idx].be; b_mant = vecs[idx].bm;
          sub_op = vecs[idx].sub; round_mode = vecs[idx].rm;
        end else begin
          in_valid = 1'b0;
        end
      end
      #1;
      if (stall_prev) begin
        check(out_valid && res_cls == h_cls && res_sign == h_sign && res_exp == h_exp
              && res_mant == h_mant && res_sticky == h_st,
              "R11", "held result changed", longint'(res_mant), longint'(h_mant));
      end
      check(out_valid == (q.size() != 0), "R11", "out_valid timing",
            longint'(out_valid), longint'(q.size() != 0));
      check(in_ready == (!out_valid || out_ready), "R11", "in_ready",
            longint'(in_ready), longint'(!out_valid || out_ready));
      if (out_valid && out_ready && q.size() != 0) begin
        e = q.pop_front();
        check(res_cls == e.cls, e.req, "class", longint'(res_cls), longint'(e.cls));
        check(res_sign == e.sign, e.req, "sign", longint'(res_sign), longint'(e.sign));
        check(res_exp == e.exp, e.req, "exponent", longint'(res_exp), longint'(e.exp));
        check(res_mant == e.mant, e.req, "mantissa", longint'(res_mant), longint'(e.mant));
        check(res_sticky == e.sticky, e.req, "sticky", longint'(res_sticky), longint'(e.sticky));
      end
      stall_prev = out_valid && !out_ready;
      h_cls = res_cls; h_sign = res_sign; h_exp = res_exp; h_mant = res_mant; h_st = res_sticky;
      pending = in_valid && !in_ready;
      if (in_valid && in_ready) begin
        q.push_back(ref_add(vecs[idx]));
        idx++;
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule